// File: doc/BRIEF.md
# Synchronizer Mode Controller

This block decides which operating mode a clock synchronizer loop runs in. It watches two qualified inputs: a flag saying the timing reference is currently unusable, and a flag saying the loop's measured phase error is inside its allowed window. From these it drives a hold control, a lock flag and a two-bit mode status. The loop filter, phase detector and controlled oscillator live elsewhere. They take the hold control from this block and report the phase-window flag back to it.

There are three states. `NORMAL` means the loop tracks the reference and reports lock. `FREERUN` means the reference is gone and the loop holds its last frequency word. `TIE_CORR` is the recovery state: the reference is back and the loop absorbs the phase offset built up while it was free-running. The transitions are as follows:
- `NORMAL`→`FREERUN` when the reference is lost.
- `FREERUN`→`TIE_CORR` when the reference returns.
- `TIE_CORR`→`FREERUN` when the reference is lost again.
- `TIE_CORR`→`NORMAL` once the phase error has stayed in its window for a parameterised run of consecutive cycles.

Reset enters `NORMAL`. All outputs are decoded from the registered state.

Top module: `sync_mode_ctrl`

## Requirements
- R1: `mode_o` encodes the state as 2'b00 for NORMAL, 2'b01 for FREERUN and 2'b10 for TIE_CORR. The value 2'b11 never appears.
- R2: Reset (active-low `rst_n`, asynchronous) puts the block in NORMAL, from any state.
- R3: In NORMAL, `ref_lost` sampled high at a clock edge moves the block to FREERUN at that edge.
- R4: In FREERUN, `ref_lost` sampled low moves the block to TIE_CORR at that edge. FREERUN never goes directly to NORMAL.
- R5: In TIE_CORR, `ref_lost` sampled high moves the block to FREERUN at that edge. This takes priority over phase qualification.
- R6: `locked` is high exactly when the state is NORMAL, so it falls in the same cycle the state leaves NORMAL.
- R7: In TIE_CORR, the block moves to NORMAL at the QUAL_CYCLES-th (default 16) consecutive edge at which `phase_ok` is sampled high while in TIE_CORR. A low sample restarts the count.
- R8: `hold` is high exactly when the state is FREERUN, and low in NORMAL and TIE_CORR.
- R9: `phase_ok` has no effect outside TIE_CORR. The qualification count starts from zero on every entry to TIE_CORR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_lost | input | 1 | Reference currently disrupted |
| phase_ok | input | 1 | Loop phase error inside its window |
| mode_o | output | 2 | Mode status (00 normal, 01 freerun, 10 TIE correction) |
| locked | output | 1 | High while in NORMAL |
| hold | output | 1 | High while the loop must keep its last frequency |

## Verification
Every mode change is due at the first rising edge that samples the triggering input. The outputs follow in that same cycle, because they decode the state register with no further register. The exit from TIE correction is due at the sixteenth qualifying edge and not at the fifteenth. The driver sets inputs on the falling edge and queues the expected mode for the next rising edge. The monitor compares a quarter period after that edge, so every expectation is checked against exactly one registered update.

// File: rtl/sync_mode_pkg.sv
package sync_mode_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'b00,
        MODE_FREERUN  = 2'b01,
        MODE_TIE_CORR = 2'b10
    } mode_e;

endpackage

// File: rtl/smc_qualifier.sv
// Counts consecutive in-window phase samples while recovery is active.
module smc_qualifier #(
    parameter int QUAL_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic phase_ok,
    output logic qual_done
);
    localparam int CW   = (QUAL_CYCLES > 2) ? $clog2(QUAL_CYCLES) : 1;
    localparam int LAST = QUAL_CYCLES - 1;

    logic [CW-1:0] run_cnt;
    logic          at_last;

    assign at_last   = (run_cnt == CW'(LAST));
    assign qual_done = enable && phase_ok && at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!enable || !phase_ok) begin
            run_cnt <= '0;
        end else if (!at_last) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/smc_fsm.sv
module smc_fsm
    import sync_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ref_lost,
    input  logic  qual_done,
    output mode_e state,
    output logic  in_tie
);
    mode_e next_state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= MODE_NORMAL;
        end else begin
            state <= next_state;
        end
    end

    always_comb begin
        next_state = state;
        unique case (state)
            MODE_NORMAL: begin
                if (ref_lost) next_state = MODE_FREERUN;
            end
            MODE_FREERUN: begin
                if (!ref_lost) next_state = MODE_TIE_CORR;
            end
            MODE_TIE_CORR: begin
                if (ref_lost)       next_state = MODE_FREERUN;
                else if (qual_done) next_state = MODE_NORMAL;
            end
            default: next_state = MODE_NORMAL;
        endcase
    end

    assign in_tie = (state == MODE_TIE_CORR);
endmodule

// File: rtl/smc_out_decode.sv
module smc_out_decode
    import sync_mode_pkg::*;
(
    input  mode_e       state,
    output logic [1:0]  mode_o,
    output logic        locked,
    output logic        hold
);
    always_comb begin
        mode_o = state;
        locked = 1'b0;
        hold   = 1'b0;
        unique case (state)
            MODE_NORMAL:   locked = 1'b1;
            MODE_FREERUN:  hold   = 1'b1;
            MODE_TIE_CORR: begin
                locked = 1'b0;
                hold   = 1'b0;
            end
            default: begin
                locked = 1'b0;
                hold   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl
    import sync_mode_pkg::*;
#(
    parameter int QUAL_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_lost,
    input  logic       phase_ok,
    output logic [1:0] mode_o,
    output logic       locked,
    output logic       hold
);
    mode_e state;
    logic  in_tie;
    logic  qual_done;

    smc_qualifier #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (in_tie),
        .phase_ok  (phase_ok),
        .qual_done (qual_done)
    );

    smc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_lost  (ref_lost),
        .qual_done (qual_done),
        .state     (state),
        .in_tie    (in_tie)
    );

    smc_out_decode u_dec (
        .state  (state),
        .mode_o (mode_o),
        .locked (locked),
        .hold   (hold)
    );
endmodule

// File: rtl/sync_mode_ctrl_chk.sv
module sync_mode_ctrl_chk #(
    parameter int QUAL_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_lost,
    input logic       phase_ok,
    input logic [1:0] mode_o,
    input logic       locked,
    input logic       hold
);
    localparam int SW = $clog2(QUAL_CYCLES + 2);
    localparam logic [1:0] M_NORM = 2'b00;
    localparam logic [1:0] M_FREE = 2'b01;
    localparam logic [1:0] M_TIE  = 2'b10;

    logic [SW-1:0] ok_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_run <= '0;
        end else if (mode_o == M_TIE && phase_ok) begin
            if (ok_run != SW'(QUAL_CYCLES + 1)) ok_run <= ok_run + 1'b1;
        end else begin
            ok_run <= '0;
        end
    end

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) mode_o != 2'b11); // R1
    AST_NORM_TO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_NORM && ref_lost) |=> mode_o == M_FREE); // R3
    AST_FREE_TO_TIE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_FREE && !ref_lost) |=> mode_o == M_TIE); // R4
    AST_TIE_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_TIE && ref_lost) |=> mode_o == M_FREE); // R5
    AST_LOCK_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        locked == (mode_o == M_NORM)); // R6
    AST_QUAL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_NORM && $past(mode_o) == M_TIE) |-> ok_run == SW'(QUAL_CYCLES)); // R7
    AST_HOLD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        hold == (mode_o == M_FREE)); // R8
endmodule

bind sync_mode_ctrl sync_mode_ctrl_chk #(.QUAL_CYCLES(QUAL_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_lost(ref_lost), .phase_ok(phase_ok),
    .mode_o(mode_o), .locked(locked), .hold(hold)
);

// File: tb/sync_mode_ctrl_test.sv
`timescale 1ns/1ps
module sync_mode_ctrl_test;
    localparam logic [1:0] M_NORM = 2'b00;
    localparam logic [1:0] M_FREE = 2'b01;
    localparam logic [1:0] M_TIE  = 2'b10;

    typedef struct {
        logic [1:0] mode;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_lost = 1'b0;
    logic       phase_ok = 1'b0;
    logic [1:0] mode_o;
    logic       locked;
    logic       hold;

    int   n_chk = 0;
    int   n_bad = 0;
    exp_t q[$];
    bit   done = 1'b0;

    sync_mode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ref_lost(ref_lost), .phase_ok(phase_ok),
        .mode_o(mode_o), .locked(locked), .hold(hold)
    );

    always #10 clk = ~clk;

    task automatic check_all(input logic [1:0] em, input string tag);
        n_chk++;
        if (mode_o !== em || locked !== (em == M_NORM) || hold !== (em == M_FREE)) begin
            n_bad++;
            $display("FAIL %s: mode=%b locked=%b hold=%b expected mode=%b locked=%b hold=%b",
                     tag, mode_o, locked, hold, em, em == M_NORM, em == M_FREE);
        end
    endtask

    task automatic step(input logic rl, input logic ok, input logic [1:0] em, input string tag);
        exp_t it;
        @(negedge clk);
        ref_lost = rl;
        phase_ok = ok;
        it.mode = em;
        it.tag  = tag;
        q.push_back(it);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                check_all(it.mode, it.tag);
            end
        end
    end

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all(M_NORM, "R2 reset state");
        rst_n = 1'b1;
        // R9: phase_ok toggling in NORMAL changes nothing
        step(0, 1, M_NORM, "R9 normal ok=1");
        step(0, 0, M_NORM, "R9 normal ok=0");
        step(0, 1, M_NORM, "R9 normal ok=1");
        step(1, 1, M_FREE, "R3 lost from normal, R6 lock drops");
        for (int i = 0; i < 20; i++) step(1, 1, M_FREE, "R8 hold in freerun, R9 ok ignored");
        step(0, 1, M_TIE, "R4 freerun to TIE");
        // R7: run broken by a low sample restarts
        for (int i = 0; i < 10; i++) step(0, 1, M_TIE, "R7 partial run");
        step(0, 0, M_TIE, "R7 break");
        for (int i = 0; i < 15; i++) step(0, 1, M_TIE, "R7 15 samples not enough");
        step(0, 1, M_NORM, "R7 16th sample exits, R6 lock");
        // R5 priority over a qualifying sample
        step(1, 0, M_FREE, "R3 lost again");
        step(0, 1, M_TIE, "R4 return");
        for (int i = 0; i < 15; i++) step(0, 1, M_TIE, "R5 building run");
        step(1, 1, M_FREE, "R5 lost beats qualification");
        step(0, 1, M_TIE, "R4 return again");
        for (int i = 0; i < 15; i++) step(0, 1, M_TIE, "R9 count restarts on entry");
        step(0, 1, M_NORM, "R9 fresh 16 samples exit");
        step(0, 0, M_NORM, "R1 stays normal");
        // R2: reset out of TIE correction
        step(1, 0, M_FREE, "R3 to freerun");
        step(0, 1, M_TIE, "R4 to TIE");
        step(0, 1, M_TIE, "R7 one sample");
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check_all(M_NORM, "R2 async reset from TIE");
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, M_NORM, "R2 normal after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule